// File: doc/BRIEF.md
# Tiered Tamper Response Controller

This block turns tamper events into an ordered, escalating sequence of protective actions. Events come from two places: a physical enclosure switch, which is always handled at the highest tier, and an anomaly monitor that reports a 2-bit severity. Each dispatched event first requests a log entry. Higher tiers then shut down networking and sessions. The top tier wipes key material, revokes the device certificate and finally enters a lockdown that does not release on its own.

Every action goes to an external agent (log store, network block, session table, key memory, certificate store) over its own request/acknowledge pair. Only one request is raised at a time, and each waits for the acknowledge of the one before it. A step that is never acknowledged is abandoned after a bounded wait, so a dead agent cannot stall the response. Events that arrive while a sequence is running are merged, keeping the highest severity, and are dispatched as a fresh sequence once the current one ends. Lockdown ignores all events and is cleared only by the factory re-provisioning input.

Top module: `tamper_response_ctrl`

## Requirements
- R1: Severity is a 2-bit code: 1 alert, 2 shutdown tier, 3 erase tier. An anomaly report with code 0 starts no sequence.
- R2: Every dispatched sequence raises the log request first, before any other request, whatever its severity.
- R3: At severity 2 or 3, after the log step, the network-disable request is raised, followed by the session-invalidate request.
- R4: At severity 3, after the session step, the key-zeroize request and then the certificate-invalidate request are raised, and lockdown is asserted after the certificate step.
- R5: At severity 1, only the log request is raised and lockdown stays low.
- R6: An enclosure-switch pulse is handled as severity 3, also when it coincides with a lower anomaly report.
- R7: While lockdown is high, no request is raised and new events are discarded. Only the re-provisioning input clears lockdown, one cycle after it is seen. Re-provisioning outside lockdown has no effect.
- R8: Events that overlap a running sequence are merged so the highest severity wins. The merged event runs as a new sequence after the current one, never at a lower tier than any merged event.
- R9: At most one request is high at a time. With an acknowledge, each request stays high until the cycle in which its acknowledge is sampled.
- R10: A request not acknowledged within ACK_WAIT cycles is dropped after exactly ACK_WAIT cycles high, and the sequence goes on to its next step as if acknowledged.
- R11: The switch pending flag is cleared only when a sequence is dispatched. A switch pulse during a running sequence yields a further severity-3 sequence.
- R12: After reset, all requests and lockdown are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| breach_i | input | 1 | Enclosure-switch pulse |
| anom_valid_i | input | 1 | Anomaly report strobe |
| anom_sev_i | input | 2 | Anomaly severity code |
| reprov_i | input | 1 | Factory re-provisioning, clears lockdown |
| log_req_o | output | 1 | Log request |
| log_ack_i | input | 1 | Log acknowledge |
| net_req_o | output | 1 | Network-disable request |
| net_ack_i | input | 1 | Network-disable acknowledge |
| sess_req_o | output | 1 | Session-invalidate request |
| sess_ack_i | input | 1 | Session-invalidate acknowledge |
| key_req_o | output | 1 | Key-zeroize request |
| key_ack_i | input | 1 | Key-zeroize acknowledge |
| cert_req_o | output | 1 | Certificate-invalidate request |
| cert_ack_i | input | 1 | Certificate-invalidate acknowledge |
| lockdown_o | output | 1 | Permanent lockdown state |

## Verification
Dispatching a pending event, which clears the pending flags, can fall in the same cycle as the capture of a new event. The bench provokes this by pulsing a second report right on the dispatch edge and a third one a cycle later. It judges the outcome by requiring a second, merged sequence at the highest of the late severities. A switch pulse in the middle of a running sequence, and a switch pulse together with a low anomaly in one cycle, probe the same collision from the switch side. The bench compares the observed order of request rises with an order it builds from the severity tier.

// File: rtl/tamper_pkg.sv
package tamper_pkg;

    typedef logic [1:0] sev_t;

    localparam sev_t SEV_NONE  = 2'd0;
    localparam sev_t SEV_ALERT = 2'd1;
    localparam sev_t SEV_SHUT  = 2'd2;
    localparam sev_t SEV_ERASE = 2'd3;

    localparam int NUM_STEPS = 5;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LOG    = 3'd1,
        PH_NET    = 3'd2,
        PH_SESS   = 3'd3,
        PH_KEY    = 3'd4,
        PH_CERT   = 3'd5,
        PH_LOCKED = 3'd6
    } phase_t;

    typedef logic [NUM_STEPS-1:0] step_vec_t;

    function automatic sev_t sev_max(input sev_t a, input sev_t b);
        return (a > b) ? a : b;
    endfunction

    // Phase that follows a finished step at a given tier.
    function automatic phase_t phase_after(input phase_t p, input sev_t s);
        phase_t n;
        case (p)
            PH_LOG:  n = (s >= SEV_SHUT)  ? PH_NET : PH_IDLE;
            PH_NET:  n = PH_SESS;
            PH_SESS: n = (s == SEV_ERASE) ? PH_KEY : PH_IDLE;
            PH_KEY:  n = PH_CERT;
            PH_CERT: n = PH_LOCKED;
            default: n = PH_IDLE;
        endcase
        return n;
    endfunction

    // One-hot request vector: bit 0 log, 1 network, 2 session, 3 key, 4 cert.
    function automatic step_vec_t step_onehot(input phase_t p);
        step_vec_t v;
        v = '0;
        case (p)
            PH_LOG:  v[0] = 1'b1;
            PH_NET:  v[1] = 1'b1;
            PH_SESS: v[2] = 1'b1;
            PH_KEY:  v[3] = 1'b1;
            PH_CERT: v[4] = 1'b1;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/tamper_event_latch.sv
module tamper_event_latch
    import tamper_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic locked_i,
    input  logic breach_i,
    input  logic anom_valid_i,
    input  sev_t anom_sev_i,
    input  logic take_i,
    output sev_t pend_sev_o
);

    logic breach_pend_q;
    sev_t anom_pend_q;
    sev_t anom_new;

    assign anom_new = anom_valid_i ? anom_sev_i : SEV_NONE;

    always_ff @(posedge clk) begin
        if (rst || locked_i) begin
            breach_pend_q <= 1'b0;
            anom_pend_q   <= SEV_NONE;
        end else begin
            breach_pend_q <= (breach_pend_q & ~take_i) | breach_i;
            anom_pend_q   <= sev_max(take_i ? SEV_NONE : anom_pend_q, anom_new);
        end
    end

    assign pend_sev_o = breach_pend_q ? SEV_ERASE : anom_pend_q;

    // R6: a switch pulse outside lockdown is pending at the erase tier next cycle
    a_r6_breach_is_erase: assert property (@(posedge clk) disable iff (rst)
        breach_i && !locked_i |=> pend_sev_o == SEV_ERASE);

    // R11: the switch flag is held until a dispatch takes it
    a_r11_breach_held: assert property (@(posedge clk) disable iff (rst)
        breach_pend_q && !take_i && !locked_i |=> breach_pend_q);

    // R8: pending severity never falls without a dispatch
    a_r8_no_drop: assert property (@(posedge clk) disable iff (rst)
        !take_i && !locked_i |=> pend_sev_o >= $past(pend_sev_o));

    // R7: nothing stays pending through lockdown
    a_r7_locked_discards: assert property (@(posedge clk) disable iff (rst)
        locked_i |=> pend_sev_o == SEV_NONE);

endmodule

// File: rtl/tamper_step_timer.sv
module tamper_step_timer #(
    parameter int ACK_WAIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic ack_i,
    output logic expired_o
);

    localparam int CW = $clog2(ACK_WAIT + 1);
    localparam logic [CW-1:0] LAST = CW'(ACK_WAIT - 1);

    logic [CW-1:0] cnt_q;

    assign expired_o = active_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !active_i || ack_i || expired_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R10: the wait counter never passes its limit
    a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R10: an unanswered step keeps counting one per cycle
    a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
        active_i && !ack_i && !expired_o |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/tamper_sequencer.sv
module tamper_sequencer
    import tamper_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sev_t      pend_sev_i,
    input  logic      reprov_i,
    input  step_vec_t step_ack_i,
    input  logic      expired_i,
    output logic      take_o,
    output step_vec_t step_req_o,
    output logic      active_o,
    output logic      cur_ack_o,
    output logic      lockdown_o
);

    phase_t state_q;
    sev_t   cur_sev_q;
    logic   step_done;

    assign step_req_o = step_onehot(state_q);
    assign active_o   = |step_req_o;
    assign cur_ack_o  = |(step_req_o & step_ack_i);
    assign step_done  = cur_ack_o | expired_i;
    assign take_o     = (state_q == PH_IDLE) && (pend_sev_i != SEV_NONE);
    assign lockdown_o = (state_q == PH_LOCKED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= PH_IDLE;
            cur_sev_q <= SEV_NONE;
        end else begin
            case (state_q)
                PH_IDLE: begin
                    if (take_o) begin
                        cur_sev_q <= pend_sev_i;
                        state_q   <= PH_LOG;
                    end
                end
                PH_LOCKED: begin
                    if (reprov_i) begin
                        cur_sev_q <= SEV_NONE;
                        state_q   <= PH_IDLE;
                    end
                end
                default: begin
                    if (step_done) begin
                        state_q <= phase_after(state_q, cur_sev_q);
                    end
                end
            endcase
        end
    end

    // R9: never two requests at once
    a_r9_single_req: assert property (@(posedge clk) disable iff (rst)
        $onehot0(step_req_o));

    // R2: the log request only starts out of idle
    a_r2_log_first: assert property (@(posedge clk) disable iff (rst)
        $rose(step_req_o[0]) |-> $past(state_q == PH_IDLE));

    // R3, R4: each later step starts right after its predecessor was held
    for (genvar g = 1; g < NUM_STEPS; g++) begin : g_order
        a_r9_step_order: assert property (@(posedge clk) disable iff (rst)
            $rose(step_req_o[g]) |-> $past(step_req_o[g-1]));
    end

    // R4: lockdown follows the certificate step
    a_r4_lock_after_cert: assert property (@(posedge clk) disable iff (rst)
        $rose(lockdown_o) |-> $past(step_req_o[NUM_STEPS-1]));

    // R7: lockdown holds unless re-provisioned
    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        lockdown_o && !reprov_i |=> lockdown_o);

    // R7: no action while locked
    a_r7_lock_quiet: assert property (@(posedge clk) disable iff (rst)
        lockdown_o |-> step_req_o == '0);

    // R9: an unanswered, unexpired request stays up
    a_r9_req_holds: assert property (@(posedge clk) disable iff (rst)
        active_o && !cur_ack_o && !expired_i |=> step_req_o == $past(step_req_o));

endmodule

// File: rtl/tamper_response_ctrl.sv
module tamper_response_ctrl
    import tamper_pkg::*;
#(
    parameter int ACK_WAIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       breach_i,
    input  logic       anom_valid_i,
    input  logic [1:0] anom_sev_i,
    input  logic       reprov_i,
    output logic       log_req_o,
    input  logic       log_ack_i,
    output logic       net_req_o,
    input  logic       net_ack_i,
    output logic       sess_req_o,
    input  logic       sess_ack_i,
    output logic       key_req_o,
    input  logic       key_ack_i,
    output logic       cert_req_o,
    input  logic       cert_ack_i,
    output logic       lockdown_o
);

    sev_t      pend_sev;
    logic      take;
    step_vec_t step_req;
    step_vec_t step_ack;
    logic      active;
    logic      cur_ack;
    logic      expired;

    assign step_ack = {cert_ack_i, key_ack_i, sess_ack_i, net_ack_i, log_ack_i};

    tamper_event_latch u_latch (
        .clk          (clk),
        .rst          (rst),
        .locked_i     (lockdown_o),
        .breach_i     (breach_i),
        .anom_valid_i (anom_valid_i),
        .anom_sev_i   (anom_sev_i),
        .take_i       (take),
        .pend_sev_o   (pend_sev)
    );

    tamper_step_timer #(.ACK_WAIT(ACK_WAIT)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .active_i  (active),
        .ack_i     (cur_ack),
        .expired_o (expired)
    );

    tamper_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .pend_sev_i (pend_sev),
        .reprov_i   (reprov_i),
        .step_ack_i (step_ack),
        .expired_i  (expired),
        .take_o     (take),
        .step_req_o (step_req),
        .active_o   (active),
        .cur_ack_o  (cur_ack),
        .lockdown_o (lockdown_o)
    );

    assign log_req_o  = step_req[0];
    assign net_req_o  = step_req[1];
    assign sess_req_o = step_req[2];
    assign key_req_o  = step_req[3];
    assign cert_req_o = step_req[4];

    // R12: quiet the cycle after reset
    a_r12_reset_quiet: assert property (@(posedge clk)
        rst |=> step_req == '0 && !lockdown_o);

endmodule

// File: tb/tamper_response_ctrl_test.sv
module tamper_response_ctrl_test;

    localparam int W    = 6;
    localparam int ACKD = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       breach = 1'b0, av = 1'b0, rp = 1'b0;
    logic [1:0] as = 2'd0;
    logic [4:0] acks = '0;
    logic [4:0] fail = '0;
    wire  [4:0] reqs;
    wire        lock;

    tamper_response_ctrl #(.ACK_WAIT(W)) uut (
        .clk(clk), .rst(rst), .breach_i(breach), .anom_valid_i(av),
        .anom_sev_i(as), .reprov_i(rp),
        .log_req_o(reqs[0]),  .log_ack_i(acks[0]),
        .net_req_o(reqs[1]),  .net_ack_i(acks[1]),
        .sess_req_o(reqs[2]), .sess_ack_i(acks[2]),
        .key_req_o(reqs[3]),  .key_ack_i(acks[3]),
        .cert_req_o(reqs[4]), .cert_ack_i(acks[4]),
        .lockdown_o(lock)
    );

    int checks = 0, errors = 0;
    longint act = 0;
    int multi = 0;
    int hold[5], dur[5], last_dur[5];
    logic [4:0] prevr = '0;
    logic prevl = 1'b0;

    // Monitor and acknowledge agents, all at the falling edge.
    always @(negedge clk) begin
        if (rst) begin
            act = 0; multi = 0; prevr = '0; prevl = 1'b0; acks = '0;
            for (int i = 0; i < 5; i++) begin
                hold[i] = 0; dur[i] = 0; last_dur[i] = 0;
            end
        end else begin
            if ($countones(reqs) > 1) multi++;
            for (int i = 0; i < 5; i++) begin
                if (reqs[i] && !prevr[i]) act = act * 8 + i + 1;
                if (reqs[i]) dur[i]++;
                else if (prevr[i]) begin last_dur[i] = dur[i]; dur[i] = 0; end
                if (!reqs[i]) begin hold[i] = 0; acks[i] = 1'b0; end
                else begin
                    hold[i]++;
                    acks[i] = (hold[i] == ACKD) && !fail[i];
                end
            end
            if (lock && !prevl) act = act * 8 + 6;
            prevr = reqs;
            prevl = lock;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint a, input longint e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, a, e);
        end
    endtask

    function automatic longint seq_code(input longint base, input int sev);
        longint c = base;
        if (sev == 0) return c;
        c = c * 8 + 1;
        if (sev >= 2) begin c = c * 8 + 2; c = c * 8 + 3; end
        if (sev == 3) begin c = c * 8 + 4; c = c * 8 + 5; c = c * 8 + 6; end
        return c;
    endfunction

    task automatic do_reset();
        rst = 1'b1; fail = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic fire(input bit b, input int sev);
        @(negedge clk);
        breach = b; av = (sev != 0) || !b; as = 2'(sev);
        if (b && sev == 0) av = 1'b0;
        @(negedge clk);
        breach = 1'b0; av = 1'b0; as = 2'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        longint e;
        do_reset();
        @(negedge clk);
        chk(reqs == 0, "R12 requests after reset", reqs, 0);
        chk(lock == 0, "R12 lockdown after reset", lock, 0);

        // R1: code 0 starts nothing
        fire(1'b0, 0);
        idle(30);
        chk(act == 0, "R1 zero severity", act, 0);

        // Sweep: anomaly tiers 1..3 and switch, each with no failure or one dead step.
        for (int src = 0; src < 4; src++) begin
            for (int fs = -1; fs < 5; fs++) begin
                int sev;
                sev = (src == 3) ? 3 : src + 1;
                do_reset();
                fail = (fs >= 0) ? 5'(1 << fs) : '0;
                if (src == 3) fire(1'b1, 0); else fire(1'b0, sev);
                idle(60);
                e = seq_code(0, sev);
                case (sev)
                    1: chk(act == e, "R5 alert order", act, e);
                    2: chk(act == e, "R3 shutdown order", act, e);
                    default: chk(act == e, (src == 3) ? "R6 switch order" : "R4 erase order", act, e);
                endcase
                chk(lock == (sev == 3), "R4 lockdown level", lock, (sev == 3));
                chk(multi == 0, "R9 single request", multi, 0);
                chk(last_dur[0] == ((fs == 0) ? W : ACKD), "R2 log duration",
                    last_dur[0], (fs == 0) ? W : ACKD);
                if (fs > 0 && ((fs <= 2 && sev >= 2) || sev == 3))
                    chk(last_dur[fs] == W, "R10 timeout length", last_dur[fs], W);
                if (sev >= 2 && fs != 1)
                    chk(last_dur[1] == ACKD, "R9 held until ack", last_dur[1], ACKD);
            end
        end

        // R8: reports on the dispatch edge and after merge to the highest.
        do_reset();
        @(negedge clk); av = 1'b1; as = 2'd1;
        @(negedge clk); as = 2'd2;
        @(negedge clk); as = 2'd1;
        @(negedge clk); av = 1'b0; as = 2'd0;
        idle(60);
        e = seq_code(seq_code(0, 1), 2);
        chk(act == e, "R8 merged overlap", act, e);
        chk(lock == 0, "R8 no lockdown", lock, 0);

        // R6, R8: switch and low anomaly together give one erase sequence.
        do_reset();
        @(negedge clk); breach = 1'b1; av = 1'b1; as = 2'd1;
        @(negedge clk); breach = 1'b0; av = 1'b0; as = 2'd0;
        idle(60);
        e = seq_code(0, 3);
        chk(act == e, "R6 switch beats alert", act, e);

        // R11: switch during a running shutdown sequence.
        do_reset();
        fire(1'b0, 2);
        idle(2);
        fire(1'b1, 0);
        idle(60);
        e = seq_code(seq_code(0, 2), 3);
        chk(act == e, "R11 switch re-dispatched", act, e);
        chk(lock == 1, "R11 lockdown reached", lock, 1);

        // R7: locked device ignores events.
        fire(1'b1, 0);
        fire(1'b0, 3);
        idle(30);
        chk(act == e, "R7 events ignored in lockdown", act, e);
        chk(lock == 1, "R7 lockdown held", lock, 1);
        @(negedge clk); rp = 1'b1;
        @(negedge clk); rp = 1'b0;
        chk(lock == 0, "R7 re-provision clears", lock, 0);
        fire(1'b0, 1);
        idle(20);
        e = e * 8 + 1;
        chk(act == e, "R7 normal after re-provision", act, e);

        // R7: re-provisioning outside lockdown changes nothing.
        do_reset();
        fire(1'b0, 2);
        rp = 1'b1;
        idle(3);
        rp = 1'b0;
        idle(40);
        e = seq_code(0, 2);
        chk(act == e, "R7 re-provision ignored", act, e);
        chk(lock == 0, "R7 no lockdown", lock, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule